// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block buffers 36-bit words between a write clock domain and a read clock domain. The two clocks run freely and may be unrelated or the same clock. Write and read pointers cross between the domains as Gray code through a chain of synchroniser flops. Because of this the status flags are pessimistic: a flag that reports "no room" or "nothing to read" may stay asserted for a few cycles after the condition has cleared.

A master reset empties the queue and captures three configuration inputs. The first selects the timing style: either a plain empty/full handshake, or a fall-through style in which the oldest word waits on the output with an output-ready flag and the write side shows an input-ready flag. The second selects one of three preset threshold offsets. The third selects how new offsets are loaded later: one bit per strobe, or one whole word per strobe.

The almost-empty and almost-full flags compare the occupancy and the free space against these offsets. A partial reset also empties the queue, but it keeps the captured timing style and the current offsets.

Top module: `xclk_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with their values unchanged, while writes and reads run on unrelated clocks.
- R2: With `cfg_fwft_i`=0 captured, `rflag_o` is 1 exactly when no word can be read and `wflag_o` is 1 when DEPTH words are stored. A read is accepted when `rd_en_i`=1 and `rflag_o`=0, and the word appears on `rdata_o` after the next read-clock edge.
- R3: A write while the queue is full and a read while it is empty are ignored, and no stored word is lost or repeated.
- R4: With `cfg_fwft_i`=1 captured, the oldest word moves to `rdata_o` without any read request and `rflag_o` (output-ready) is then 1. While output-ready is 1 and `rd_en_i` is 0, `rdata_o` holds its value. `rd_en_i`=1 consumes that word. Capacity is DEPTH stored words plus the one on the output, and `wflag_o` (input-ready) is 0 only when storage holds DEPTH words.
- R5: At master reset both offsets take the preset selected by `cfg_def_i`: 0 gives 8, 1 gives 16, and 2 or 3 give 64.
- R6: `ae_o` is 1 when the read-side word count (including the output word in fall-through timing) is at or below the almost-empty offset. `af_o` is 1 when DEPTH minus the stored-word count (excluding the output word) is at or below the almost-full offset.
- R7: With `cfg_ser_i`=0 captured, each `ld_wr_i` strobe copies `ld_data_i` into an offset. Strobes alternate, starting at master reset with almost-empty and then almost-full.
- R8: With `cfg_ser_i`=1 captured, each `ld_wr_i` strobe shifts `ld_data_i[0]` into the MSB of the joined value {almost-full, almost-empty}. After 2*log2(DEPTH) strobes, the first bit sent is bit 0 of the almost-empty offset.
- R9: While `rst_ni` is low and the write clock runs, the queue empties and the three configuration inputs are captured. Any loaded offsets are replaced by the preset.
- R10: `prst_ni` low empties the queue but keeps the timing style and the current offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Master reset, active low |
| prst_ni | input | 1 | Partial reset, active low |
| cfg_fwft_i | input | 1 | Timing style captured at master reset (1 = fall-through) |
| cfg_def_i | input | 2 | Preset offset select captured at master reset |
| cfg_ser_i | input | 1 | Offset load method captured at master reset (1 = serial) |
| ld_wr_i | input | 1 | Offset load strobe (write clock) |
| ld_data_i | input | log2(DEPTH) | Offset load value, or bit 0 as the serial bit |
| wr_en_i | input | 1 | Write request |
| wdata_i | input | DW | Write data |
| wflag_o | output | 1 | Full (standard) or input-ready (fall-through) |
| rd_en_i | input | 1 | Read request |
| rdata_o | output | DW | Read data |
| rflag_o | output | 1 | Empty (standard) or output-ready (fall-through) |
| ae_o | output | 1 | Almost-empty |
| af_o | output | 1 | Almost-full |

## Verification
The bench builds the block with its defaults: 36-bit words, a depth of 256 and two synchroniser stages. The write clock runs at 10 ns and the read clock at 13 ns. At depth 256 all three presets, including 64, sit well inside the range, and the queue can still be filled to full (and to DEPTH+1 in fall-through timing) with directed writes. The unrelated clock periods make the Gray pointers cross at every phase relationship during the random traffic in both timing styles.

// File: rtl/xclk_fifo_pkg.sv
`timescale 1ns/1ps
package xclk_fifo_pkg;
  typedef enum logic [1:0] {
    OFS_8   = 2'd0,
    OFS_16  = 2'd1,
    OFS_64  = 2'd2,
    OFS_64B = 2'd3
  } ofs_sel_e;

  function automatic int unsigned preset_offset(input logic [1:0] sel);
    case (ofs_sel_e'(sel))
      OFS_8:   return 8;
      OFS_16:  return 16;
      default: return 64;
    endcase
  endfunction
endpackage

// File: rtl/xclk_fifo_sync.sv
`timescale 1ns/1ps
module xclk_fifo_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/xclk_fifo_mem.sv
`timescale 1ns/1ps
module xclk_fifo_mem #(
  parameter int DW    = 36,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          rclk_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ram_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) ram_q[waddr_i] <= wdata_i;
  end

  always_ff @(posedge rclk_i) begin
    if (re_i) rdata_o <= ram_q[raddr_i];
  end
endmodule

// File: rtl/xclk_fifo_wside.sv
`timescale 1ns/1ps
module xclk_fifo_wside #(
  parameter int DEPTH = 256,
  parameter int AW    = 8,
  parameter int PW    = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] af_off_i,
  input  logic [PW-1:0] rgray_sync_i,
  output logic [PW-1:0] wgray_o,
  output logic [AW-1:0] waddr_o,
  output logic          we_o,
  output logic          full_o,
  output logic          af_o
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [PW-1:0] wbin_q, wbin_nxt, rbin_s, used, space;

  // full: pointers differ only in the two top Gray bits
  assign full_o   = (wgray_o == {~rgray_sync_i[PW-1:PW-2], rgray_sync_i[PW-3:0]});
  assign we_o     = wr_en_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(we_o);
  assign waddr_o  = wbin_q[AW-1:0];

  always_comb begin
    for (int i = 0; i < PW; i++) rbin_s[i] = ^(rgray_sync_i >> i);
  end

  assign used  = wbin_q - rbin_s;
  assign space = DEPTH_P - used;
  assign af_o  = space <= {1'b0, af_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_o <= '0;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_o <= wbin_nxt ^ (wbin_nxt >> 1);
    end
  end
endmodule

// File: rtl/xclk_fifo_rside.sv
`timescale 1ns/1ps
module xclk_fifo_rside #(
  parameter int AW = 8,
  parameter int PW = AW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fwft_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] ae_off_i,
  input  logic [PW-1:0] wgray_sync_i,
  output logic [PW-1:0] rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          re_o,
  output logic          rflag_o,
  output logic          ae_o
);
  logic [PW-1:0] rbin_q, rbin_nxt, wbin_s, occ;
  logic          ov_q, mem_empty;

  assign mem_empty = (rgray_o == wgray_sync_i);
  // fall-through: refill the output stage whenever it is free or being consumed
  assign re_o      = ~mem_empty & (fwft_i ? (~ov_q | rd_en_i) : rd_en_i);
  assign rbin_nxt  = rbin_q + PW'(re_o);
  assign raddr_o   = rbin_q[AW-1:0];
  assign rflag_o   = fwft_i ? ov_q : mem_empty;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin_s[i] = ^(wgray_sync_i >> i);
  end

  assign occ  = wbin_s - rbin_q + PW'(ov_q);
  assign ae_o = occ <= {1'b0, ae_off_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_o <= '0;
      ov_q    <= 1'b0;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_o <= rbin_nxt ^ (rbin_nxt >> 1);
      if (!fwft_i)      ov_q <= 1'b0;
      else if (re_o)    ov_q <= 1'b1;
      else if (rd_en_i) ov_q <= 1'b0;
    end
  end
endmodule

// File: rtl/xclk_fifo_cfg.sv
`timescale 1ns/1ps
module xclk_fifo_cfg
  import xclk_fifo_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_fwft_i,
  input  logic [1:0]    cfg_def_i,
  input  logic          cfg_ser_i,
  input  logic          ld_wr_i,
  input  logic [AW-1:0] ld_data_i,
  output logic          fwft_o,
  output logic [AW-1:0] ae_off_o,
  output logic [AW-1:0] af_off_o
);
  logic ser_q, par_sel_q;

  // configuration captured synchronously while master reset is held
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      fwft_o    <= cfg_fwft_i;
      ser_q     <= cfg_ser_i;
      ae_off_o  <= AW'(preset_offset(cfg_def_i));
      af_off_o  <= AW'(preset_offset(cfg_def_i));
      par_sel_q <= 1'b0;
    end else if (ld_wr_i) begin
      if (ser_q) begin
        {af_off_o, ae_off_o} <= {ld_data_i[0], af_off_o, ae_off_o[AW-1:1]};
      end else begin
        if (par_sel_q) af_off_o <= ld_data_i;
        else           ae_off_o <= ld_data_i;
        par_sel_q <= ~par_sel_q;
      end
    end
  end
endmodule

// File: rtl/xclk_fifo.sv
`timescale 1ns/1ps
module xclk_fifo #(
  parameter int DW          = 36,
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW         = $clog2(DEPTH),
  localparam int PW         = AW + 1
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          prst_ni,
  input  logic          cfg_fwft_i,
  input  logic [1:0]    cfg_def_i,
  input  logic          cfg_ser_i,
  input  logic          ld_wr_i,
  input  logic [AW-1:0] ld_data_i,
  input  logic          wr_en_i,
  input  logic [DW-1:0] wdata_i,
  output logic          wflag_o,
  input  logic          rd_en_i,
  output logic [DW-1:0] rdata_o,
  output logic          rflag_o,
  output logic          ae_o,
  output logic          af_o
);
  logic          arst_n, fwft, full, we, re;
  logic [AW-1:0] ae_off, af_off, waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_rs, rgray_ws;

  assign arst_n  = rst_ni & prst_ni;
  assign wflag_o = fwft ? ~full : full;

  xclk_fifo_cfg #(.AW(AW)) u_cfg (
    .clk_i(wclk_i), .rst_ni(rst_ni), .cfg_fwft_i(cfg_fwft_i), .cfg_def_i(cfg_def_i),
    .cfg_ser_i(cfg_ser_i), .ld_wr_i(ld_wr_i), .ld_data_i(ld_data_i),
    .fwft_o(fwft), .ae_off_o(ae_off), .af_off_o(af_off)
  );

  xclk_fifo_wside #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wside (
    .clk_i(wclk_i), .rst_ni(arst_n), .wr_en_i(wr_en_i), .af_off_i(af_off),
    .rgray_sync_i(rgray_ws), .wgray_o(wgray), .waddr_o(waddr), .we_o(we),
    .full_o(full), .af_o(af_o)
  );

  xclk_fifo_rside #(.AW(AW), .PW(PW)) u_rside (
    .clk_i(rclk_i), .rst_ni(arst_n), .fwft_i(fwft), .rd_en_i(rd_en_i),
    .ae_off_i(ae_off), .wgray_sync_i(wgray_rs), .rgray_o(rgray), .raddr_o(raddr),
    .re_o(re), .rflag_o(rflag_o), .ae_o(ae_o)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i(rclk_i), .rst_ni(arst_n), .d_i(wgray), .q_o(wgray_rs)
  );

  xclk_fifo_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i(wclk_i), .rst_ni(arst_n), .d_i(rgray), .q_o(rgray_ws)
  );

  xclk_fifo_mem #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .wclk_i(wclk_i), .we_i(we), .waddr_i(waddr), .wdata_i(wdata_i),
    .rclk_i(rclk_i), .re_i(re), .raddr_i(raddr), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/xclk_fifo_chk.sv
`timescale 1ns/1ps
module xclk_fifo_chk #(
  parameter int DW = 36,
  parameter int PW = 9
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          arst_ni,
  input logic          fwft_i,
  input logic          wr_en_i,
  input logic          rd_en_i,
  input logic          full_i,
  input logic [PW-1:0] wgray_i,
  input logic [PW-1:0] rgray_i,
  input logic [DW-1:0] rdata_i,
  input logic          rflag_i,
  input logic          ae_i,
  input logic          af_i
);
  assert_wgray_step_R1: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1);

  assert_rgray_step_R1: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    $countones(rgray_i ^ $past(rgray_i)) <= 1);

  assert_no_overflow_R3: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    full_i && wr_en_i |=> $stable(wgray_i));

  assert_no_underflow_R3: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    !fwft_i && rflag_i |=> $stable(rgray_i));

  assert_std_hold_R2: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    !fwft_i && !rd_en_i |=> $stable(rdata_i));

  assert_fwft_hold_R4: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    fwft_i && rflag_i && !rd_en_i |=> $stable(rdata_i) && rflag_i);

  assert_full_af_R6: assert property (@(posedge wclk_i) disable iff (!arst_ni)
    full_i |-> af_i);

  assert_empty_ae_R6: assert property (@(posedge rclk_i) disable iff (!arst_ni)
    !fwft_i && rflag_i |-> ae_i);
endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .PW(PW)) u_chk (
  .wclk_i(wclk_i), .rclk_i(rclk_i), .arst_ni(arst_n), .fwft_i(fwft),
  .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .full_i(full), .wgray_i(wgray),
  .rgray_i(rgray), .rdata_i(rdata_o), .rflag_i(rflag_o), .ae_i(ae_o), .af_i(af_o)
);

// File: tb/xclk_fifo_bench.sv
`timescale 1ns/1ps
module xclk_fifo_bench;
  localparam int DW = 36;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic wclk = 1'b0, rclk = 1'b0;
  logic rst_n = 1'b0, prst_n = 1'b1;
  logic cfg_fwft = 1'b0, cfg_ser = 1'b0;
  logic [1:0] cfg_def = 2'd0;
  logic ld_wr = 1'b0;
  logic [AW-1:0] ld_data = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic wflag, rflag, ae, af;
  logic [DW-1:0] rdata;

  int n_cmp = 0, n_bad = 0;
  bit fwft_m = 1'b0;
  logic [DW-1:0] q[$];

  always #5 wclk = ~wclk;
  always #6.5 rclk = ~rclk;

  xclk_fifo u_xclk_fifo (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .prst_ni(prst_n),
    .cfg_fwft_i(cfg_fwft), .cfg_def_i(cfg_def), .cfg_ser_i(cfg_ser),
    .ld_wr_i(ld_wr), .ld_data_i(ld_data), .wr_en_i(wr_en), .wdata_i(wdata),
    .wflag_o(wflag), .rd_en_i(rd_en), .rdata_o(rdata), .rflag_o(rflag),
    .ae_o(ae), .af_o(af)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] rnd_word();
    return DW'({$urandom(), $urandom()});
  endfunction

  task automatic settle();
    repeat (8) @(negedge rclk);
    repeat (8) @(negedge wclk);
  endtask

  task automatic mreset(input bit fw, input logic [1:0] dsel, input bit ser);
    @(negedge wclk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; ld_wr = 1'b0;
    cfg_fwft = fw; cfg_def = dsel; cfg_ser = ser;
    repeat (4) @(negedge wclk);
    repeat (2) @(negedge rclk);
    @(negedge wclk) rst_n = 1'b1;
    cfg_fwft = ~fw; cfg_def = ~dsel; cfg_ser = ~ser; // must no longer matter
    fwft_m = fw;
    q.delete();
    settle();
  endtask

  task automatic preset();
    @(negedge wclk) prst_n = 1'b0;
    repeat (3) @(negedge rclk);
    @(negedge wclk) prst_n = 1'b1;
    q.delete();
    settle();
  endtask

  task automatic wr1(input logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1; wdata = d;
    if (fwft_m ? wflag : !wflag) q.push_back(d);
    @(negedge wclk) wr_en = 1'b0;
  endtask

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) wr1(rnd_word());
  endtask

  task automatic ld(input logic [AW-1:0] v);
    @(negedge wclk); ld_wr = 1'b1; ld_data = v;
    @(negedge wclk) ld_wr = 1'b0;
  endtask

  task automatic drain();
    logic [DW-1:0] e;
    while (q.size() > 0) begin
      @(negedge rclk);
      if (!fwft_m && !rflag) begin
        rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
        e = q.pop_front();
        chk("R1 order", 64'(rdata), 64'(e));
      end else if (fwft_m && rflag) begin
        e = q.pop_front();
        chk("R1 order", 64'(rdata), 64'(e));
        rd_en = 1'b1;
        @(negedge rclk) rd_en = 1'b0;
      end
    end
    settle();
  endtask

  task automatic run_rand(input int n);
    bit wdone = 1'b0;
    fork
      begin : wr_proc
        for (int i = 0; i < n; i++) begin
          @(negedge wclk);
          wr_en = ($urandom % 3) != 0;
          wdata = rnd_word();
          if (wr_en && (fwft_m ? wflag : !wflag)) q.push_back(wdata);
        end
        @(negedge wclk) wr_en = 1'b0;
        wdone = 1'b1;
      end
      begin : rd_proc
        bit pend = 1'b0;
        logic [DW-1:0] e;
        forever begin
          @(negedge rclk);
          if (pend) begin
            e = q.pop_front();
            chk("R1 random", 64'(rdata), 64'(e));
            pend = 1'b0;
          end
          rd_en = 1'b0;
          if (wdone && q.size() == 0) break;
          if (($urandom % 2) == 1 && q.size() > 0) begin
            if (fwft_m && rflag) begin
              e = q.pop_front();
              chk("R1 random", 64'(rdata), 64'(e));
              rd_en = 1'b1;
            end else if (!fwft_m && !rflag) begin
              rd_en = 1'b1;
              pend = 1'b1;
            end
          end
        end
      end
    join
    settle();
  endtask

  initial begin
    repeat (150000) @(posedge wclk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    logic [2*AW-1:0] sv;
    void'($urandom(32'h5eed_1234));

    // standard timing, preset 8, parallel loading
    mreset(1'b0, 2'd0, 1'b0);
    chk("R9 empty after reset", 64'(rflag), 64'd1);
    chk("R9 not full after reset", 64'(wflag), 64'd0);
    chk("R9 ae after reset", 64'(ae), 64'd1);
    chk("R9 af after reset", 64'(af), 64'd0);

    fill(8); settle();
    chk("R5 preset 8 ae at 8", 64'(ae), 64'd1);
    chk("R2 not empty", 64'(rflag), 64'd0);
    fill(1); settle();
    chk("R6 ae clear at 9", 64'(ae), 64'd0);
    fill(238); settle();
    chk("R6 af clear at 247", 64'(af), 64'd0);
    fill(1); settle();
    chk("R6 af set at 248", 64'(af), 64'd1);
    fill(7); settle();
    chk("R2 not full at 255", 64'(wflag), 64'd0);
    fill(1); settle();
    chk("R2 full at 256", 64'(wflag), 64'd1);
    wr1(rnd_word()); // ignored: must not overwrite
    drain();
    chk("R3 empty after drain", 64'(rflag), 64'd1);
    @(negedge rclk) rd_en = 1'b1; // read while empty
    @(negedge rclk) rd_en = 1'b0;
    d = rnd_word();
    wr1(d); settle();
    @(negedge rclk) rd_en = 1'b1;
    @(negedge rclk) rd_en = 1'b0;
    chk("R3 read while empty ignored", 64'(rdata), 64'(d));
    q.delete(); settle();
    chk("R2 empty again", 64'(rflag), 64'd1);

    run_rand(3000);

    // parallel offsets: ae=20 then af=30
    ld(AW'(20)); ld(AW'(30));
    fill(20); settle();
    chk("R7 ae set at 20", 64'(ae), 64'd1);
    fill(1); settle();
    chk("R7 ae clear at 21", 64'(ae), 64'd0);
    fill(204); settle();
    chk("R7 af clear at 225", 64'(af), 64'd0);
    fill(1); settle();
    chk("R7 af set at 226", 64'(af), 64'd1);

    preset();
    chk("R10 empty after partial reset", 64'(rflag), 64'd1);
    chk("R10 not full after partial reset", 64'(wflag), 64'd0);
    fill(20); settle();
    chk("R10 ae offset 20 kept", 64'(ae), 64'd1);
    fill(1); settle();
    chk("R10 ae clear at 21", 64'(ae), 64'd0);
    drain();

    // standard timing, preset 16
    mreset(1'b0, 2'd1, 1'b0);
    fill(16); settle();
    chk("R5 preset 16 ae at 16", 64'(ae), 64'd1);
    fill(1); settle();
    chk("R5 preset 16 ae clear at 17", 64'(ae), 64'd0);
    drain();

    // fall-through timing, preset 64, serial loading
    mreset(1'b1, 2'd2, 1'b1);
    chk("R9 output-ready low after reset", 64'(rflag), 64'd0);
    chk("R9 input-ready high after reset", 64'(wflag), 64'd1);
    chk("R9 ae after reset", 64'(ae), 64'd1);
    fill(64); settle();
    chk("R5 preset 64 ae at 64", 64'(ae), 64'd1);
    fill(1); settle();
    chk("R5 preset 64 ae clear at 65", 64'(ae), 64'd0);
    drain();
    chk("R4 output-ready low when empty", 64'(rflag), 64'd0);
    d = rnd_word();
    wr1(d); settle();
    chk("R4 word falls through", 64'(rflag), 64'd1);
    chk("R4 fall-through data", 64'(rdata), 64'(d));
    drain();

    sv = {AW'(7), AW'(5)}; // af=7, ae=5
    for (int k = 0; k < 2 * AW; k++) ld(AW'(sv[k]));
    fill(5); settle();
    chk("R8 serial ae set at 5", 64'(ae), 64'd1);
    fill(1); settle();
    chk("R8 serial ae clear at 6", 64'(ae), 64'd0);
    fill(243); settle();
    chk("R8 af clear at 249", 64'(af), 64'd0);
    fill(1); settle();
    chk("R8 af set at 250 (stored 249)", 64'(af), 64'd1);
    fill(6); settle();
    chk("R4 input-ready at 256", 64'(wflag), 64'd1);
    fill(1); settle();
    chk("R4 input-ready low at 257", 64'(wflag), 64'd0);
    wr1(rnd_word()); // ignored
    chk("R3 queue holds DEPTH+1", 64'(q.size()), 64'(DEPTH + 1));
    drain();

    preset();
    chk("R10 output-ready low after partial reset", 64'(rflag), 64'd0);
    d = rnd_word();
    wr1(d); settle();
    chk("R10 fall-through kept", 64'(rflag), 64'd1);
    chk("R10 fall-through data", 64'(rdata), 64'(d));
    fill(4); settle();
    chk("R10 serial ae offset 5 kept", 64'(ae), 64'd1);
    drain();

    run_rand(3000);

    summary();
    $finish;
  end
endmodule